// File: doc/BRIEF.md
# Two-Thread Instruction Buffer with Priority Decode

This block sits between instruction fetch and decode in a core that runs two hardware threads at once. A two-state slot machine hands the fetch slot to each thread on alternate cycles. A returned fetch word goes into the queue of the thread it is tagged with. Each thread has its own eight-entry queue. Each cycle, decode can take up to two instructions. A priority rule decides how those two lanes are split between the queues. The rule uses one 3-bit priority value per thread.

Each thread also has a four-entry return-address stack. A fetched call pushes its link address onto the stack of its own thread. A fetched return reads the top of that stack in the same cycle and then pops it. A flush input for each thread empties that thread's queue. The other thread is not affected.

The fetch slot state machine has two states. SLOT_T0 means thread 0 owns the slot, and SLOT_T1 means thread 1 owns it. There are two transitions. ADVANCE_T1 moves SLOT_T0 to SLOT_T1 and ADVANCE_T0 moves SLOT_T1 to SLOT_T0. One of them fires on every clock edge outside reset. Reset forces SLOT_T0.

Top module: `smt_ibuf`

## Requirements
- R1: After reset the slot owner is thread 0, and the owner swaps on every clock edge. While neither queue is full, fetch_go is 1 and fetch_tid equals the owner.
- R2: If the owner's queue holds 8 entries and the other queue is not full, the slot goes to the other thread. If both queues are full, fetch_go is 0.
- R3: A fetch return with fr_valid=1 enters queue fr_tid (0 or 1) in arrival order. It is dropped if that queue already holds 8 entries or if that thread is flushed in the same cycle. Each queue is read oldest first on the decode lanes.
- R4: If one thread has a strictly higher priority (unsigned 3-bit), dec_room is 2 and that thread has 2 or more queued entries, then both lanes come from that thread.
- R5: Under unequal priority in all other cases, the higher-priority thread's entries fill lanes first and the other thread fills the lanes left over. Lane 0 is always filled before lane 1. The number of valid lanes never exceeds dec_room, and a dec_room of 3 counts as 2.
- R6: Under equal priority with dec_room 2 and both queues non-empty, lane 0 comes from thread 0 and lane 1 from thread 1. Otherwise thread 0 fills lanes first and thread 1 fills the rest.
- R7: A call (fr_call=1) pushes fr_link onto the stack of fr_tid. A return (fr_ret=1 with fr_call=0) shows that stack's top on ras_target, with ras_valid=1, in the same cycle, and then pops it. The two stacks are independent. When fr_call and fr_ret are both 1, fr_call wins.
- R8: A push onto a full stack drops the oldest entry. After five calls, four returns give the four newest links, newest first.
- R9: A return on an empty stack gives ras_valid=0 and ras_target=0. ras_valid and ras_target are also 0 in every cycle without a return.
- R10: A flush bit (flush[t]) empties queue t by the next cycle. In the flush cycle no lane comes from thread t. The other queue and both stacks keep their contents.
- R11: On the first cycle after reset, both queues and both stacks are empty, dec_valid is 0, fetch_go is 1 and fetch_tid is 0. Any idle lane shows thread bit 0 and instruction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_go | output | 1 | A fetch request is issued this cycle |
| fetch_tid | output | 1 | Thread that the fetch request is for |
| fr_valid | input | 1 | A fetch return is present |
| fr_tid | input | 1 | Thread the fetch return belongs to |
| fr_instr | input | INSTR_W | Returned instruction word |
| fr_call | input | 1 | The returned instruction is a call |
| fr_ret | input | 1 | The returned instruction is a return |
| fr_link | input | ADDR_W | Link address pushed on a call |
| ras_valid | output | 1 | The return target is valid |
| ras_target | output | ADDR_W | Predicted return target |
| prio0 | input | PRIO_W | Priority of thread 0 |
| prio1 | input | PRIO_W | Priority of thread 1 |
| dec_room | input | 2 | Number of instructions decode accepts this cycle |
| dec_valid | output | 2 | Valid bit of each decode lane |
| dec_tid | output | 2 | Thread of each decode lane |
| dec_instr0 | output | INSTR_W | Instruction on lane 0 |
| dec_instr1 | output | INSTR_W | Instruction on lane 1 |
| flush | input | 2 | Flush request, one bit per thread |

## Verification
The following outputs are combinational functions of the current inputs and the registered state: the fetch grant, the two decode lanes and the return prediction. Each one is therefore due in the same cycle as the stimulus that causes it. Queue contents, stack contents and the slot owner change at the next rising edge, so the effect of a push, pop, dequeue or flush first shows on the outputs of the following cycle. The bench drives inputs on the falling edge and compares against its model 1 ns later. It then advances the model as the rising edge will. Every expected value is thus taken in the cycle the result is due.

// File: rtl/smt_ibuf_pkg.sv
package smt_ibuf_pkg;
    typedef enum logic {
        SLOT_T0 = 1'b0,
        SLOT_T1 = 1'b1
    } slot_e;
endpackage

// File: rtl/smt_ibuf_queue.sv
// Per-thread instruction FIFO: one push, up to two pops, single-cycle flush.
module smt_ibuf_queue #(
    parameter int DEPTH = 8,
    parameter int W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic [1:0]       pop_n,
    input  logic             flush,
    output logic [CNT_W-1:0] count,
    output logic [W-1:0]     head0,
    output logic [W-1:0]     head1
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic             push_ok;

    assign push_ok = push && (count < CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
        end else if (flush) begin
            rd_q  <= wr_q;
            count <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + PTR_W'(1);
            rd_q  <= rd_q + PTR_W'(pop_n);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_q] <= push_data;
    end

    assign head0 = mem[rd_q];
    assign head1 = mem[rd_q + PTR_W'(1)];
endmodule

// File: rtl/smt_ibuf_ras.sv
// Circular return-address stack; overflow overwrites the oldest entry.
module smt_ibuf_ras #(
    parameter int DEPTH = 4,
    parameter int W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         top_valid
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] top_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            top_q <= top_q + PTR_W'(1);
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && top_valid) begin
            top_q <= top_q - PTR_W'(1);
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[top_q + PTR_W'(1)] <= push_data;
    end

    assign top_valid = (cnt_q != '0);
    assign top_data  = top_valid ? mem[top_q] : '0;
endmodule

// File: rtl/smt_ibuf_arb.sv
// Splits the two decode lanes between the thread queues by priority.
module smt_ibuf_arb #(
    parameter int CNT_W = 4,
    parameter int PRIO_W = 3,
    parameter int W = 32
) (
    input  logic [CNT_W-1:0]  cnt0,
    input  logic [CNT_W-1:0]  cnt1,
    input  logic [PRIO_W-1:0] prio0,
    input  logic [PRIO_W-1:0] prio1,
    input  logic [1:0]        room,
    input  logic [W-1:0]      h00,
    input  logic [W-1:0]      h01,
    input  logic [W-1:0]      h10,
    input  logic [W-1:0]      h11,
    output logic [1:0]        take0,
    output logic [1:0]        take1,
    output logic [1:0]        dec_valid,
    output logic [1:0]        dec_tid,
    output logic [W-1:0]      dec_instr0,
    output logic [W-1:0]      dec_instr1
);
    logic             first;
    logic [CNT_W-1:0] cf, cs;
    logic [1:0]       rm, nf, ns, rest, used;
    logic [W-1:0]     hf0, hf1, hs0, hs1;

    always_comb begin
        first = (prio1 > prio0);
        rm    = (room == 2'd3) ? 2'd2 : room;
        cf    = first ? cnt1 : cnt0;
        cs    = first ? cnt0 : cnt1;
        hf0   = first ? h10 : h00;
        hf1   = first ? h11 : h01;
        hs0   = first ? h00 : h10;
        hs1   = first ? h01 : h11;
        nf    = (cf >= CNT_W'(rm)) ? rm : cf[1:0];
        rest  = rm - nf;
        ns    = (cs >= CNT_W'(rest)) ? rest : cs[1:0];
        if ((prio0 == prio1) && (rm == 2'd2) && (cnt0 != '0) && (cnt1 != '0)) begin
            nf = 2'd1;
            ns = 2'd1;
        end
        used       = nf + ns;
        take0      = first ? ns : nf;
        take1      = first ? nf : ns;
        dec_valid  = {used == 2'd2, used != 2'd0};
        dec_tid    = 2'b00;
        dec_instr0 = '0;
        dec_instr1 = '0;
        if (used != 2'd0) begin
            dec_tid[0] = (nf != 2'd0) ? first : ~first;
            dec_instr0 = (nf != 2'd0) ? hf0 : hs0;
        end
        if (used == 2'd2) begin
            if (nf == 2'd2) begin
                dec_tid[1] = first;
                dec_instr1 = hf1;
            end else if (nf == 2'd1) begin
                dec_tid[1] = ~first;
                dec_instr1 = hs0;
            end else begin
                dec_tid[1] = ~first;
                dec_instr1 = hs1;
            end
        end
    end
endmodule

// File: rtl/smt_ibuf.sv
module smt_ibuf
    import smt_ibuf_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int ADDR_W = 32,
    parameter int QDEPTH = 8,
    parameter int RDEPTH = 4,
    parameter int PRIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               fetch_go,
    output logic               fetch_tid,
    input  logic               fr_valid,
    input  logic               fr_tid,
    input  logic [INSTR_W-1:0] fr_instr,
    input  logic               fr_call,
    input  logic               fr_ret,
    input  logic [ADDR_W-1:0]  fr_link,
    output logic               ras_valid,
    output logic [ADDR_W-1:0]  ras_target,
    input  logic [PRIO_W-1:0]  prio0,
    input  logic [PRIO_W-1:0]  prio1,
    input  logic [1:0]         dec_room,
    output logic [1:0]         dec_valid,
    output logic [1:0]         dec_tid,
    output logic [INSTR_W-1:0] dec_instr0,
    output logic [INSTR_W-1:0] dec_instr1,
    input  logic [1:0]         flush
);
    localparam int QCNT_W = $clog2(QDEPTH + 1);

    slot_e               state_q, state_d;
    logic [QCNT_W-1:0]   q_cnt   [2];
    logic [QCNT_W-1:0]   arb_cnt [2];
    logic [INSTR_W-1:0]  q_h0    [2];
    logic [INSTR_W-1:0]  q_h1    [2];
    logic [1:0]          take    [2];
    logic [ADDR_W-1:0]   r_top   [2];
    logic [1:0]          r_val;
    logic [1:0]          q_full;
    logic                ret_ev;
    logic                owner;

    assign ret_ev = fr_valid && fr_ret && !fr_call;

    generate
        for (genvar t = 0; t < 2; t++) begin : g_thr
            logic hit;
            assign hit        = fr_valid && (fr_tid == 1'(t));
            assign q_full[t]  = (q_cnt[t] == QCNT_W'(QDEPTH));
            assign arb_cnt[t] = flush[t] ? '0 : q_cnt[t];

            smt_ibuf_queue #(.DEPTH(QDEPTH), .W(INSTR_W)) u_queue (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (hit),
                .push_data (fr_instr),
                .pop_n     (take[t]),
                .flush     (flush[t]),
                .count     (q_cnt[t]),
                .head0     (q_h0[t]),
                .head1     (q_h1[t])
            );

            smt_ibuf_ras #(.DEPTH(RDEPTH), .W(ADDR_W)) u_ras (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (hit && fr_call),
                .pop       (hit && ret_ev),
                .push_data (fr_link),
                .top_data  (r_top[t]),
                .top_valid (r_val[t])
            );
        end
    endgenerate

    smt_ibuf_arb #(.CNT_W(QCNT_W), .PRIO_W(PRIO_W), .W(INSTR_W)) u_arb (
        .cnt0       (arb_cnt[0]),
        .cnt1       (arb_cnt[1]),
        .prio0      (prio0),
        .prio1      (prio1),
        .room       (dec_room),
        .h00        (q_h0[0]),
        .h01        (q_h1[0]),
        .h10        (q_h0[1]),
        .h11        (q_h1[1]),
        .take0      (take[0]),
        .take1      (take[1]),
        .dec_valid  (dec_valid),
        .dec_tid    (dec_tid),
        .dec_instr0 (dec_instr0),
        .dec_instr1 (dec_instr1)
    );

    // Fetch slot state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_T0;
        else        state_q <= state_d;
    end

    // Transitions ADVANCE_T1 / ADVANCE_T0
    always_comb begin
        unique case (state_q)
            SLOT_T0: state_d = SLOT_T1;
            SLOT_T1: state_d = SLOT_T0;
            default: state_d = SLOT_T0;
        endcase
    end

    // Fetch grant outputs
    always_comb begin
        owner     = (state_q == SLOT_T1);
        fetch_go  = 1'b1;
        fetch_tid = owner;
        unique case (state_q)
            SLOT_T0: begin
                if (q_full[0]) begin
                    fetch_tid = 1'b1;
                    fetch_go  = !q_full[1];
                end
            end
            SLOT_T1: begin
                if (q_full[1]) begin
                    fetch_tid = 1'b0;
                    fetch_go  = !q_full[0];
                end
            end
            default: fetch_go = 1'b0;
        endcase
        if (!fetch_go) fetch_tid = 1'b0;
    end

    assign ras_valid  = ret_ev && r_val[fr_tid];
    assign ras_target = ras_valid ? r_top[fr_tid] : '0;
endmodule

// File: rtl/smt_ibuf_checker.sv
module smt_ibuf_checker #(
    parameter int QDEPTH = 8,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 32,
    localparam int QCNT_W = $clog2(QDEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_go,
    input logic              fetch_tid,
    input logic [1:0]        dec_valid,
    input logic [1:0]        dec_tid,
    input logic [1:0]        dec_room,
    input logic [PRIO_W-1:0] prio0,
    input logic [PRIO_W-1:0] prio1,
    input logic [1:0]        flush,
    input logic              ras_valid,
    input logic [ADDR_W-1:0] ras_target,
    input logic [QCNT_W-1:0] cnt0,
    input logic [QCNT_W-1:0] cnt1
);
    logic armed;
    logic full0, full1;
    assign full0 = (cnt0 == QCNT_W'(QDEPTH));
    assign full1 = (cnt1 == QCNT_W'(QDEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fetch_go && !full0 && !full1 && $past(fetch_go) && !$past(full0) && !$past(full1))
        |-> (fetch_tid != $past(fetch_tid)));

    assert_skip_full0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full0 |-> !(fetch_go && !fetch_tid));

    assert_skip_full1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full1 |-> !(fetch_go && fetch_tid));

    assert_high_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((prio0 > prio1) && (cnt0 >= QCNT_W'(2)) && !flush[0] && (dec_room == 2'd2))
        |-> (dec_valid == 2'b11 && dec_tid == 2'b00));

    assert_lane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid != 2'b10);

    assert_room_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec_valid) <= ((dec_room == 2'd3) ? 2 : int'(dec_room)));

    assert_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_valid |-> (ras_target == '0));

    assert_flush0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush[0] |=> (cnt0 == '0));

    assert_flush1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush[1] |=> (cnt1 == '0));
endmodule

bind smt_ibuf smt_ibuf_checker #(.QDEPTH(QDEPTH), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_go   (fetch_go),
    .fetch_tid  (fetch_tid),
    .dec_valid  (dec_valid),
    .dec_tid    (dec_tid),
    .dec_room   (dec_room),
    .prio0      (prio0),
    .prio1      (prio1),
    .flush      (flush),
    .ras_valid  (ras_valid),
    .ras_target (ras_target),
    .cnt0       (q_cnt[0]),
    .cnt1       (q_cnt[1])
);

// File: tb/tb_smt_ibuf.sv
module tb_smt_ibuf;
    localparam int QD = 8;
    localparam int RD = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_go, fetch_tid;
    logic        fr_valid, fr_tid, fr_call, fr_ret;
    logic [31:0] fr_instr, fr_link;
    logic        ras_valid;
    logic [31:0] ras_target;
    logic [2:0]  prio0, prio1;
    logic [1:0]  dec_room, dec_valid, dec_tid, flush;
    logic [31:0] dec_instr0, dec_instr1;

    always #5 clk = ~clk;

    smt_ibuf dut (
        .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .fetch_tid(fetch_tid),
        .fr_valid(fr_valid), .fr_tid(fr_tid), .fr_instr(fr_instr), .fr_call(fr_call),
        .fr_ret(fr_ret), .fr_link(fr_link), .ras_valid(ras_valid), .ras_target(ras_target),
        .prio0(prio0), .prio1(prio1), .dec_room(dec_room), .dec_valid(dec_valid),
        .dec_tid(dec_tid), .dec_instr0(dec_instr0), .dec_instr1(dec_instr1), .flush(flush)
    );

    // Reference model
    logic [31:0] mq [2][QD];
    int          mc [2];
    logic [31:0] mr [2][RD];
    int          mrc [2];
    int          mst;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input bit fv, input bit tid, input logic [31:0] ins, input bit call,
                         input bit ret, input logic [31:0] link, input logic [1:0] room,
                         input logic [2:0] p0, input logic [2:0] p1, input logic [1:0] fl);
        fr_valid = fv; fr_tid = tid; fr_instr = ins; fr_call = call; fr_ret = ret;
        fr_link = link; dec_room = room; prio0 = p0; prio1 = p1; flush = fl;
    endtask

    // Checks outputs of the current cycle, then advances the model past the next edge.
    task automatic step(input string ras_tag, input string dec_tag);
        int c[2], pre[2], st[2], si[2], tk[2];
        int n, f, s, rm, nf, ns, rest;
        logic [1:0] edv, etid;
        bit eg, et, f0, f1, ev;
        logic [31:0] etg;
        string tag;
        #1;
        for (int t = 0; t < 2; t++) begin
            c[t] = flush[t] ? 0 : mc[t];
            pre[t] = mc[t];
            tk[t] = 0;
        end
        f = (prio1 > prio0) ? 1 : 0;
        s = 1 - f;
        rm = (dec_room > 2) ? 2 : int'(dec_room);
        n = 0;
        if (prio0 == prio1 && rm == 2 && c[0] > 0 && c[1] > 0) begin
            st[0] = 0; si[0] = 0; st[1] = 1; si[1] = 0; n = 2;
        end else begin
            nf = (c[f] < rm) ? c[f] : rm;
            rest = rm - nf;
            ns = (c[s] < rest) ? c[s] : rest;
            for (int k = 0; k < nf; k++) begin st[n] = f; si[n] = k; n++; end
            for (int k = 0; k < ns; k++) begin st[n] = s; si[n] = k; n++; end
        end
        edv = (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : 2'b11;
        etid = 2'b00;
        for (int k = 0; k < n; k++) etid[k] = st[k][0];
        if (dec_tag != "") tag = dec_tag;
        else if (prio0 == prio1) tag = "R6";
        else if (c[f] >= 2 && rm == 2) tag = "R4";
        else tag = "R5";
        chk(tag, dec_valid, edv);
        chk(tag, dec_tid, etid);
        if (n > 0) chk("R3", dec_instr0, mq[st[0]][si[0]]); else chk("R11", dec_instr0, 0);
        if (n > 1) chk("R3", dec_instr1, mq[st[1]][si[1]]); else chk("R11", dec_instr1, 0);
        // fetch grant
        f0 = (mc[0] == QD); f1 = (mc[1] == QD);
        if (mst == 0) begin eg = !(f0 && f1); et = f0 ? (f1 ? 1'b0 : 1'b1) : 1'b0; end
        else begin eg = !(f0 && f1); et = f1 ? 1'b0 : 1'b1; end
        tag = (f0 || f1) ? "R2" : "R1";
        chk(tag, fetch_go, eg);
        chk(tag, fetch_tid, et);
        // return prediction
        ev = 0; etg = 0;
        if (fr_valid && fr_ret && !fr_call && mrc[fr_tid] > 0) begin
            ev = 1; etg = mr[fr_tid][mrc[fr_tid]-1];
        end
        if (ras_tag != "") tag = ras_tag; else tag = ev ? "R7" : "R9";
        chk(tag, ras_valid, ev);
        chk(tag, ras_target, etg);
        // advance model
        for (int k = 0; k < n; k++) tk[st[k]]++;
        for (int t = 0; t < 2; t++) begin
            for (int j = 0; j + tk[t] < QD; j++) mq[t][j] = mq[t][j+tk[t]];
            mc[t] = flush[t] ? 0 : mc[t] - tk[t];
        end
        if (fr_valid && !flush[fr_tid] && pre[fr_tid] < QD) begin
            mq[fr_tid][mc[fr_tid]] = fr_instr;
            mc[fr_tid]++;
        end
        if (fr_valid && fr_call) begin
            if (mrc[fr_tid] == RD) begin
                for (int j = 0; j < RD - 1; j++) mr[fr_tid][j] = mr[fr_tid][j+1];
                mrc[fr_tid] = RD - 1;
            end
            mr[fr_tid][mrc[fr_tid]] = fr_link;
            mrc[fr_tid]++;
        end else if (fr_valid && fr_ret && mrc[fr_tid] > 0) begin
            mrc[fr_tid]--;
        end
        mst = 1 - mst;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        mc[0] = 0; mc[1] = 0; mrc[0] = 0; mrc[1] = 0; mst = 0;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 3'd0, 2'b00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 2'd2, 3'd0, 3'd0, 2'b00);
        #1;
        chk("R11", fetch_go, 1);
        chk("R11", fetch_tid, 0);
        chk("R11", dec_valid, 0);
        chk("R11", ras_valid, 0);
        step("", "R11");

        // R1/R2/R3: fill thread 0 past its depth, then thread 1
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, 32'h100 + i, 0, 0, 0, 2'd0, 3'd1, 3'd1, 2'b00);
            step("", "");
        end
        for (int i = 0; i < 9; i++) begin
            drive(1, 1, 32'h200 + i, 0, 0, 0, 2'd0, 3'd1, 3'd1, 2'b00);
            step("", "");
        end
        drive(0, 0, 0, 0, 0, 0, 2'd0, 3'd1, 3'd1, 2'b00);
        step("", "");
        // R4: thread 0 higher priority drains two per cycle
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 0, 0, 0, 0, 2'd2, 3'd5, 3'd2, 2'b00);
            step("", "R4");
        end
        // R5: one entry in thread 0, remaining lane from thread 1
        drive(1, 0, 32'h1AA, 0, 0, 0, 2'd0, 3'd5, 3'd2, 2'b00);
        step("", "");
        drive(0, 0, 0, 0, 0, 0, 2'd2, 3'd5, 3'd2, 2'b00);
        step("", "R5");
        drive(0, 0, 0, 0, 0, 0, 2'd3, 3'd1, 3'd6, 2'b00);
        step("", "R5");
        // R10: refill thread 0, flush thread 1 with a same-cycle push to it
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 32'h300 + i, 0, 0, 0, 2'd0, 3'd3, 3'd3, 2'b00);
            step("", "");
        end
        drive(1, 1, 32'h3FF, 0, 0, 0, 2'd2, 3'd3, 3'd3, 2'b10);
        step("", "R10");
        drive(0, 0, 0, 0, 0, 0, 2'd2, 3'd3, 3'd3, 2'b00);
        step("", "R10");
        drive(0, 0, 0, 0, 0, 0, 2'd2, 3'd3, 3'd3, 2'b00);
        step("", "R10");

        // R7/R8/R9: stack overflow and underflow on thread 0, thread 1 independent
        for (int i = 0; i < 5; i++) begin
            drive(1, 0, 32'h400 + i, 1, 0, 32'hA000 + i, 2'd2, 3'd2, 3'd2, 2'b00);
            step("", "");
        end
        drive(1, 1, 32'h500, 1, 0, 32'hB000, 2'd2, 3'd2, 3'd2, 2'b00);
        step("", "");
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, 32'h600 + i, 0, 1, 0, 2'd2, 3'd2, 3'd2, 2'b00);
            step("R8", "");
        end
        drive(1, 0, 32'h700, 0, 1, 0, 2'd2, 3'd2, 3'd2, 2'b00);
        step("R9", "");
        drive(1, 1, 32'h701, 0, 1, 0, 2'd2, 3'd2, 3'd2, 2'b00);
        step("R7", "");
        drive(1, 1, 32'h702, 0, 1, 0, 2'd2, 3'd2, 3'd2, 2'b00);
        step("R9", "");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit cl, rt;
            logic [2:0] p0, p1;
            r  = $urandom % 8;
            cl = (r == 0);
            rt = (r == 1);
            p0 = 3'($urandom);
            p1 = ($urandom % 3 == 0) ? p0 : 3'($urandom);
            drive(($urandom % 4) != 0, 1'($urandom), $urandom, cl, rt, $urandom,
                  2'($urandom), p0, p1, (($urandom % 16) == 0) ? 2'($urandom) : 2'b00);
            step("", "");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule